// File: doc/BRIEF.md
# Pipeline Forwarding and Load-Use Stall Unit

This unit sits beside a five-stage integer pipeline and resolves read-after-write dependencies between instructions that are in flight together. It compares the two source register numbers of the instruction in execute against the destinations of the older instructions in the memory and writeback stages. From those comparisons it drives one operand-bypass select for each ALU input. The register file, ALU and memories belong to the surrounding pipeline.

Every instruction writes the register file only in its last stage. The register file is written early in a cycle and read later in the same cycle, so an instruction three slots behind its producer reads the new value directly. A consumer one or two slots behind takes the value from a bypass path, and the younger producer wins when both later stages hold the same destination. A load is the one case a bypass cannot cover in time. When the instruction in decode reads the register that a load in execute will write, the unit holds the PC and the fetch/decode register and puts a bubble into execute. This lasts exactly one cycle. After it, the loaded value reaches the consumer from the writeback stage.

The outputs depend only on the current stage inputs, apart from one flag that prevents a second consecutive stall. All pins are plain control signals, so there is no valid/ready handshake and no back-pressure.

Top module: `hz_unit`

## Requirements
- R1: Each operand select is 2 bits: 2'b00 takes the register file value, 2'b10 takes the memory-stage result and 2'b01 takes the writeback-stage result. Select A serves `ex_rs1` and select B serves `ex_rs2`.
- R2: An execute source equal to the memory-stage destination gives select 2'b10 in the same cycle.
- R3: An execute source that matches only the writeback-stage destination gives 2'b01. When it matches both, it gives 2'b10.
- R4: A destination counts as a producer only when that stage's valid bit and its write enable are both 1. Otherwise the select stays 2'b00.
- R5: Register 0 never causes forwarding or a stall. This holds even when a producer names register 0 as its destination.
- R6: `pc_hold` and `ex_bubble` rise in the same cycle when execute holds a valid, writing load whose nonzero destination equals a source that decode marks as used. A non-load producer or an unused source causes no stall.
- R7: A stall lasts one cycle at most. In the cycle after a stall cycle, both stall outputs are 0 whatever the inputs.
- R8: A decode source that matches only a memory-stage or writeback-stage destination causes no stall.
- R9: After reset, with all stages idle, both selects are 2'b00 and both stall outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_rs1 | input | REG_W (5) | First source of the decode-stage instruction |
| dec_rs2 | input | REG_W (5) | Second source of the decode-stage instruction |
| dec_rs1_used | input | 1 | Decode instruction reads dec_rs1 |
| dec_rs2_used | input | 1 | Decode instruction reads dec_rs2 |
| ex_rs1 | input | REG_W (5) | First source of the execute-stage instruction |
| ex_rs2 | input | REG_W (5) | Second source of the execute-stage instruction |
| ex_rd | input | REG_W (5) | Destination of the execute-stage instruction |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | REG_W (5) | Destination of the memory-stage instruction |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | REG_W (5) | Destination of the writeback-stage instruction |
| wb_valid | input | 1 | Writeback stage holds a real instruction |
| wb_we | input | 1 | Writeback-stage instruction writes a register |
| fwd_a_sel | output | 2 | Bypass select for ALU operand A |
| fwd_b_sel | output | 2 | Bypass select for ALU operand B |
| pc_hold | output | 1 | Hold the PC and the fetch/decode register this cycle |
| ex_bubble | output | 1 | Load a bubble into execute at the next edge |

## Verification
Both selects and both stall outputs are combinational, so each one is due in the cycle its inputs are applied. The bench applies inputs on the falling edge and samples one time unit later, well before the next rising edge. The only registered effect is the R7 suppression of a second stall, which appears one rising edge after a stall cycle. The bench checks it by holding the inputs across that edge and sampling again after the next falling edge. The table walk inserts an idle cycle after every vector, so no vector inherits suppression from the one before it.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // Operand source select, shared by both ALU inputs.
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  localparam int unsigned HZ_NUM_SRC = 2;
endpackage

// File: rtl/hz_match.sv
// One producer/consumer comparison: a hit needs a live, writing producer
// whose destination is a nonzero register equal to the consumer's source.
module hz_match #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic             prod_valid,
  input  logic             prod_we,
  output logic             hit
);
  logic dst_nonzero;

  always_comb begin
    dst_nonzero = (dst != '0);
    hit         = prod_valid && prod_we && dst_nonzero && (src == dst);
  end
endmodule

// File: rtl/hz_fwd_sel.sv
// Bypass select for one ALU operand; the memory stage is younger and wins.
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_valid,
  input  logic             mem_we,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_valid,
  input  logic             wb_we,
  output fwd_sel_e         sel
);
  logic mem_hit;
  logic wb_hit;

  hz_match #(.REG_W(REG_W)) u_mem_cmp (
    .src(src), .dst(mem_rd), .prod_valid(mem_valid), .prod_we(mem_we), .hit(mem_hit)
  );

  hz_match #(.REG_W(REG_W)) u_wb_cmp (
    .src(src), .dst(wb_rd), .prod_valid(wb_valid), .prod_we(wb_we), .hit(wb_hit)
  );

  always_comb begin
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end
endmodule

// File: rtl/hz_loaduse.sv
// Load-use detection between the decode sources and a load in execute.
// A stall is never issued in two consecutive cycles.
module hz_loaduse #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0][REG_W-1:0]   dec_src,
  input  logic [NUM_SRC-1:0]              dec_used,
  input  logic [REG_W-1:0]                ex_rd,
  input  logic                            ex_valid,
  input  logic                            ex_we,
  input  logic                            ex_is_load,
  output logic                            stall
);
  logic [NUM_SRC-1:0] src_hit;
  logic               stalled_q;
  logic               need_stall;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    hz_match #(.REG_W(REG_W)) u_ld_cmp (
      .src       (dec_src[i]),
      .dst       (ex_rd),
      .prod_valid(ex_valid && ex_is_load && dec_used[i]),
      .prod_we   (ex_we),
      .hit       (src_hit[i])
    );
  end

  always_comb begin
    need_stall = |src_hit;
    stall      = need_stall && !stalled_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stalled_q <= 1'b0;
    else        stalled_q <= stall;
  end

  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall) else $error("stall held twice"); // R7
  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ex_valid && ex_we && ex_is_load && ex_rd != '0)) else $error("stall without load"); // R6
endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] dec_rs1,
  input  logic [REG_W-1:0] dec_rs2,
  input  logic             dec_rs1_used,
  input  logic             dec_rs2_used,
  input  logic [REG_W-1:0] ex_rs1,
  input  logic [REG_W-1:0] ex_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_valid,
  input  logic             ex_we,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_valid,
  input  logic             mem_we,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_valid,
  input  logic             wb_we,
  output logic [1:0]       fwd_a_sel,
  output logic [1:0]       fwd_b_sel,
  output logic             pc_hold,
  output logic             ex_bubble
);
  localparam int unsigned NSRC = HZ_NUM_SRC;

  logic [NSRC-1:0][REG_W-1:0] ex_src;
  logic [NSRC-1:0][REG_W-1:0] dec_src;
  logic [NSRC-1:0]            dec_used;
  fwd_sel_e                   op_sel [NSRC];
  logic                       stall;

  assign ex_src   = {ex_rs2, ex_rs1};
  assign dec_src  = {dec_rs2, dec_rs1};
  assign dec_used = {dec_rs2_used, dec_rs1_used};

  for (genvar i = 0; i < NSRC; i++) begin : g_op
    hz_fwd_sel #(.REG_W(REG_W)) u_sel (
      .src      (ex_src[i]),
      .mem_rd   (mem_rd),
      .mem_valid(mem_valid),
      .mem_we   (mem_we),
      .wb_rd    (wb_rd),
      .wb_valid (wb_valid),
      .wb_we    (wb_we),
      .sel      (op_sel[i])
    );
  end

  hz_loaduse #(.REG_W(REG_W), .NUM_SRC(NSRC)) u_ldu (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_src   (dec_src),
    .dec_used  (dec_used),
    .ex_rd     (ex_rd),
    .ex_valid  (ex_valid),
    .ex_we     (ex_we),
    .ex_is_load(ex_is_load),
    .stall     (stall)
  );

  assign fwd_a_sel = op_sel[0];
  assign fwd_b_sel = op_sel[1];
  assign pc_hold   = stall;
  assign ex_bubble = stall;

  AST_ZERO_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1 == '0) |-> (fwd_a_sel == FWD_RF)) else $error("r0 forwarded"); // R5
  AST_MEM_OVER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && ex_rs2 != '0 && ex_rs2 == mem_rd) |-> (fwd_b_sel == FWD_MEM))
    else $error("memory stage lost priority"); // R3
  AST_WB_NEEDS_PRODUCER: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_sel == FWD_WB) |-> (wb_valid && wb_we && wb_rd == ex_rs1)) else $error("stale wb bypass"); // R4
  AST_MEM_NEEDS_PRODUCER: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_b_sel == FWD_MEM) |-> (mem_valid && mem_we && mem_rd == ex_rs2)) else $error("stale mem bypass"); // R2
endmodule

// File: tb/test_hz_unit.sv
module test_hz_unit;
  localparam int CLK_P = 10;
  localparam int RW    = 5;

  typedef struct packed {
    logic [RW-1:0] ers1, ers2, mrd;
    logic          mv, mw;
    logic [RW-1:0] wrd;
    logic          wv, ww;
    logic [RW-1:0] erd;
    logic          ev, ew, el;
    logic [RW-1:0] d1, d2;
    logic          u1, u2;
    logic [1:0]    xa, xb;
    logic          xs;
  } vec_t;

  function automatic vec_t mk(int ers1, int ers2, int mrd, int mv, int mw,
                              int wrd, int wv, int ww, int erd, int ev, int ew, int el,
                              int d1, int d2, int u1, int u2, int xa, int xb, int xs);
    vec_t v;
    v.ers1 = RW'(ers1); v.ers2 = RW'(ers2); v.mrd = RW'(mrd);
    v.mv = 1'(mv); v.mw = 1'(mw); v.wrd = RW'(wrd); v.wv = 1'(wv); v.ww = 1'(ww);
    v.erd = RW'(erd); v.ev = 1'(ev); v.ew = 1'(ew); v.el = 1'(el);
    v.d1 = RW'(d1); v.d2 = RW'(d2); v.u1 = 1'(u1); v.u2 = 1'(u2);
    v.xa = 2'(xa); v.xb = 2'(xb); v.xs = 1'(xs);
    return v;
  endfunction

  localparam int NV = 12;
  //                          ers1 ers2 mrd mv mw wrd wv ww erd ev ew el d1 d2 u1 u2 xa xb xs
  localparam vec_t VEC [NV] = '{
    mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),   // R9 idle
    mk(3, 0, 3, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2, 0, 0),   // R2 operand A from mem
    mk(0, 4, 0, 0, 0, 4, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0),   // R3 operand B from wb
    mk(5, 5, 5, 1, 1, 5, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 2, 2, 0),   // R3 mem beats wb
    mk(6, 0, 6, 1, 0, 6, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0),   // R4 mem not writing
    mk(7, 7, 7, 0, 1, 7, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),   // R4 stages not valid
    mk(0, 0, 0, 1, 1, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),   // R5 register 0
    mk(0, 0, 0, 0, 0, 0, 0, 0, 8, 1, 1, 1, 8, 0, 1, 0, 0, 0, 1),   // R6 load-use on rs1
    mk(0, 0, 0, 0, 0, 0, 0, 0, 8, 1, 1, 1, 0, 8, 0, 0, 0, 0, 0),   // R6 source unused
    mk(0, 0, 0, 0, 0, 0, 0, 0, 8, 1, 1, 0, 8, 8, 1, 1, 0, 0, 0),   // R6 producer not a load
    mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 1, 1, 0, 0, 0),   // R5 load to register 0
    mk(9, 10, 9, 1, 1, 10, 1, 1, 0, 0, 0, 0, 9, 10, 1, 1, 2, 1, 0) // R8 no stall on later producers
  };
  localparam string TAG [NV] = '{"R9", "R2", "R3", "R3", "R4", "R4", "R5", "R6", "R6", "R6", "R5", "R8"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RW-1:0] dec_rs1, dec_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic dec_rs1_used, dec_rs2_used, ex_valid, ex_we, ex_is_load;
  logic mem_valid, mem_we, wb_valid, wb_we;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic pc_hold, ex_bubble;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_P/2) clk = ~clk;

  hz_unit #(.REG_W(RW)) i_hz_unit (
    .clk(clk), .rst_n(rst_n),
    .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .dec_rs1_used(dec_rs1_used), .dec_rs2_used(dec_rs2_used),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_valid(ex_valid), .ex_we(ex_we),
    .ex_is_load(ex_is_load), .mem_rd(mem_rd), .mem_valid(mem_valid), .mem_we(mem_we),
    .wb_rd(wb_rd), .wb_valid(wb_valid), .wb_we(wb_we),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .pc_hold(pc_hold), .ex_bubble(ex_bubble)
  );

  task automatic drive(input vec_t v);
    ex_rs1 = v.ers1; ex_rs2 = v.ers2; mem_rd = v.mrd; mem_valid = v.mv; mem_we = v.mw;
    wb_rd = v.wrd; wb_valid = v.wv; wb_we = v.ww;
    ex_rd = v.erd; ex_valid = v.ev; ex_we = v.ew; ex_is_load = v.el;
    dec_rs1 = v.d1; dec_rs2 = v.d2; dec_rs1_used = v.u1; dec_rs2_used = v.u2;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input int xa, input int xb, input int xs);
    check(req, "fwd_a_sel", int'(fwd_a_sel), xa);
    check(req, "fwd_b_sel", int'(fwd_b_sel), xb);
    check(req, "pc_hold", int'(pc_hold), xs);
    check(req, "ex_bubble", int'(ex_bubble), xs);
  endtask

  // Apply at the falling edge, sample one time unit later.
  task automatic apply(input vec_t v);
    @(negedge clk);
    drive(v);
    #1;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    drive(VEC[0]);
    repeat (3) @(posedge clk);
    #1;
    check_all("R9", 0, 0, 0);   // during reset, idle
    @(negedge clk);
    rst_n = 1'b1;
    apply(VEC[0]);
    check_all("R9", 0, 0, 0);   // after reset, idle

    // Table walk, each vector followed by one idle cycle.
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check_all(TAG[i], int'(VEC[i].xa), int'(VEC[i].xb), int'(VEC[i].xs));
      apply(VEC[0]);
    end

    // R7: load-use inputs held across an edge stall only once.
    apply(mk(0, 0, 0, 0, 0, 0, 0, 0, 12, 1, 1, 1, 0, 12, 0, 1, 0, 0, 0));
    check("R6", "pc_hold rs2 hazard", int'(pc_hold), 1);
    @(negedge clk); #1;
    check("R7", "pc_hold second cycle", int'(pc_hold), 0);
    check("R7", "ex_bubble second cycle", int'(ex_bubble), 0);
    @(negedge clk); #1;
    check("R6", "pc_hold re-armed", int'(pc_hold), 1);
    apply(VEC[0]);

    // Load r8 then dependent: stall, bubble drains, then bypass from writeback.
    apply(mk(0, 0, 0, 0, 0, 0, 0, 0, 8, 1, 1, 1, 8, 0, 1, 0, 0, 0, 0));
    check("R6", "load-use stall", int'(pc_hold), 1);
    apply(mk(0, 0, 8, 1, 1, 0, 0, 0, 0, 0, 0, 0, 8, 0, 1, 0, 0, 0, 0));
    check("R8", "no stall with load in mem", int'(pc_hold), 0);
    apply(mk(8, 0, 0, 0, 0, 8, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    check("R3", "loaded value from writeback", int'(fwd_a_sel), 1);
    check("R8", "no stall afterwards", int'(ex_bubble), 0);

    // R1: operands are independent, one from each stage.
    apply(mk(14, 15, 15, 1, 1, 14, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    check("R1", "operand A from wb", int'(fwd_a_sel), 1);
    check("R1", "operand B from mem", int'(fwd_b_sel), 2);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule